// File: doc/BRIEF.md
# Single-Access Link Host Sequencer

This block is the host end of a request/response link in the TileLink Uncached Lightweight style. It issues one non-burst access at a time. A user request carries an opcode, an address, write data and a size, and is captured into a packet register when the block takes it. The block then steps through four phases: idle, waiting for the device to signal readiness, sending, and waiting for the reply. The request channel valid is raised only while sending. The response channel ready is raised while sending and while waiting for the reply.

Each wait phase has its own down-counter, loaded when the phase is entered and decremented on every cycle the wait goes on. A wait that would outlast its bound is abandoned: the block returns to idle and raises a sticky error. The same error is raised when the device presents a response outside the reply-wait phase. On a reply, the response data is latched and reported with a one-cycle pulse. In that same cycle a new request can be taken and sent without a pass through idle.

Top module: `tlul_host_seq`

## Requirements
- R1: After reset, `a_valid_o`, `d_ready_o`, `rsp_valid_o` and `err_o` are all low, and the block is idle.
- R2: `a_valid_o` is high only in the send phase. The send phase lasts exactly one cycle and is always followed by the reply-wait phase.
- R3: `d_ready_o` is high in the send and reply-wait phases and low in the idle and ready-wait phases.
- R4: When idle with `req_valid_i` high, a high `a_ready_i` gives `a_valid_o` in the next cycle. A low `a_ready_i` enters the ready wait, and `a_valid_o` then rises in the cycle after the first cycle that sees `a_ready_i` high.
- R5: The ready wait is loaded with RDY_BOUND on entry. If `a_ready_i` is seen low on RDY_BOUND+1 consecutive ready-wait cycles, the block returns to idle without sending and `err_o` rises.
- R6: A cycle in the reply wait with `d_valid_i` high completes the access: in the next cycle `rsp_valid_o` is high for one cycle and `rsp_data_o` equals the `d_data_i` of that cycle, and it is held until the next reply.
- R7: The reply wait is loaded with RSP_BOUND after the send cycle. If `d_valid_i` stays low for RSP_BOUND+1 reply-wait cycles, the block returns to idle and `err_o` rises.
- R8: `d_valid_i` high in the idle, ready-wait or send phase sets `err_o`. Once set, `err_o` stays high until reset.
- R9: `a_opcode_o`, `a_address_o`, `a_data_o` and `a_size_o` show the fields of the last request taken, passed through unchanged, and stay stable from the send cycle until the reply or timeout.
- R10: In a reply cycle with `req_valid_i` high, the new request is taken. It goes straight to the send phase if `a_ready_i` is high, and into the ready wait otherwise.
- R11: `req_taken_o` is high exactly in the cycles where `req_valid_i` is high and the block is idle, or in the reply wait with `d_valid_i` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Synchronous active-low reset |
| req_valid_i | input | 1 | User wants an access |
| req_opcode_i | input | 3 | Access opcode, passed through |
| req_addr_i | input | AW | Access address |
| req_data_i | input | DW | Write data |
| req_size_i | input | 2 | Log2 of the byte count |
| req_taken_o | output | 1 | Request captured this cycle |
| a_valid_o | output | 1 | Request channel valid |
| a_opcode_o | output | 3 | Request channel opcode |
| a_address_o | output | AW | Request channel address |
| a_data_o | output | DW | Request channel data |
| a_size_o | output | 2 | Request channel size |
| a_ready_i | input | 1 | Device ready for a request |
| d_valid_i | input | 1 | Device response valid |
| d_data_i | input | DW | Device response data |
| d_ready_o | output | 1 | Host accepts a response |
| rsp_valid_o | output | 1 | One-cycle pulse: response latched |
| rsp_data_o | output | DW | Latched response data |
| err_o | output | 1 | Sticky protocol error |

## Verification
The bench builds the block with RDY_BOUND of 3 and RSP_BOUND of 4, with a 16-bit address and 32-bit data. These small bounds bring both timeouts within a few cycles. This lets the bench hit the exact last cycle before each timeout and the first cycle after it, alongside waits that end just in time. Directed sequences cover the immediate send, the delayed send, back-to-back replies with and without ready, and responses that arrive out of phase. Every cycle is compared against a behavioural model.

// File: rtl/tlul_host_pkg.sv
// Package: shared phase encoding and fixed field widths of the link host.
// Assumes nothing beyond the single-outstanding-access protocol.
package tlul_host_pkg;

    localparam int OPW = 3;   // opcode width on the request channel
    localparam int SZW = 2;   // size field width (log2 of bytes)

    typedef enum logic [1:0] {
        PH_IDLE     = 2'd0,
        PH_WAIT_RDY = 2'd1,
        PH_SEND     = 2'd2,
        PH_WAIT_RSP = 2'd3
    } phase_e;

endpackage

// File: rtl/tlul_host_bound_cnt.sv
// Module: down-counter bounding one wait phase.
// Loads BOUND on load_i, decrements on dec_i while non-zero, reports zero.
// Assumes load_i and dec_i are never both high; BOUND is at least 1.
module tlul_host_bound_cnt #(
    parameter int BOUND = 8
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic load_i,
    input  logic dec_i,
    output logic zero_o
);
    localparam int CW = (BOUND < 1) ? 1 : $clog2(BOUND + 1);

    logic [CW-1:0] cnt_q;

    // Counter register: cleared on reset, loaded on phase entry, decremented per wait cycle.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= CW'(BOUND);
        end else if (dec_i && (cnt_q != '0)) begin
            cnt_q <= cnt_q - CW'(1);
        end
    end

    assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/tlul_host_phase_fsm.sv
// Module: phase sequencer of the link host.
// Decides the next phase from the user request, device handshakes and the
// two bound counters; emits counter controls and event strobes.
// Assumes the counters report zero combinationally from their registers.
module tlul_host_phase_fsm
    import tlul_host_pkg::*;
(
    input  logic   clk_i,
    input  logic   rst_ni,
    input  logic   req_valid_i,
    input  logic   a_ready_i,
    input  logic   d_valid_i,
    input  logic   rdy_zero_i,
    input  logic   rsp_zero_i,
    output phase_e phase_o,
    output logic   accept_o,
    output logic   rdy_load_o,
    output logic   rdy_dec_o,
    output logic   rsp_load_o,
    output logic   rsp_dec_o,
    output logic   got_rsp_o,
    output logic   fault_o
);
    phase_e phase_q, phase_d;
    logic   timeout;
    logic   stray;

    // Next-phase and control decode for the current phase.
    always_comb begin
        phase_d    = phase_q;
        accept_o   = 1'b0;
        rdy_load_o = 1'b0;
        rdy_dec_o  = 1'b0;
        rsp_load_o = 1'b0;
        rsp_dec_o  = 1'b0;
        got_rsp_o  = 1'b0;
        timeout    = 1'b0;
        unique case (phase_q)
            PH_IDLE: begin
                if (req_valid_i) begin
                    accept_o = 1'b1;
                    if (a_ready_i) begin
                        phase_d = PH_SEND;
                    end else begin
                        phase_d    = PH_WAIT_RDY;
                        rdy_load_o = 1'b1;
                    end
                end
            end
            PH_WAIT_RDY: begin
                if (a_ready_i) begin
                    phase_d = PH_SEND;
                end else if (rdy_zero_i) begin
                    timeout = 1'b1;
                    phase_d = PH_IDLE;
                end else begin
                    rdy_dec_o = 1'b1;
                end
            end
            PH_SEND: begin
                phase_d    = PH_WAIT_RSP;
                rsp_load_o = 1'b1;
            end
            PH_WAIT_RSP: begin
                if (d_valid_i) begin
                    got_rsp_o = 1'b1;
                    if (req_valid_i) begin
                        accept_o = 1'b1;
                        if (a_ready_i) begin
                            phase_d = PH_SEND;
                        end else begin
                            phase_d    = PH_WAIT_RDY;
                            rdy_load_o = 1'b1;
                        end
                    end else begin
                        phase_d = PH_IDLE;
                    end
                end else if (rsp_zero_i) begin
                    timeout = 1'b1;
                    phase_d = PH_IDLE;
                end else begin
                    rsp_dec_o = 1'b1;
                end
            end
            default: phase_d = PH_IDLE;
        endcase
    end

    // A response outside the reply wait is a protocol violation.
    always_comb begin
        stray = d_valid_i && (phase_q != PH_WAIT_RSP);
    end

    assign fault_o = timeout || stray;

    // Phase register.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            phase_q <= PH_IDLE;
        end else begin
            phase_q <= phase_d;
        end
    end

    assign phase_o = phase_q;

endmodule

// File: rtl/tlul_host_pkt_reg.sv
// Module: request packet holder.
// Captures the user request fields on capture_i and holds them otherwise,
// so the request channel fields stay stable through send and reply wait.
module tlul_host_pkt_reg
    import tlul_host_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input  logic           clk_i,
    input  logic           rst_ni,
    input  logic           capture_i,
    input  logic [OPW-1:0] opcode_i,
    input  logic [AW-1:0]  addr_i,
    input  logic [DW-1:0]  data_i,
    input  logic [SZW-1:0] size_i,
    output logic [OPW-1:0] opcode_o,
    output logic [AW-1:0]  addr_o,
    output logic [DW-1:0]  data_o,
    output logic [SZW-1:0] size_o
);
    // Packet fields: cleared on reset, loaded when a request is taken.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            opcode_o <= '0;
            addr_o   <= '0;
            data_o   <= '0;
            size_o   <= '0;
        end else if (capture_i) begin
            opcode_o <= opcode_i;
            addr_o   <= addr_i;
            data_o   <= data_i;
            size_o   <= size_i;
        end
    end

endmodule

// File: rtl/tlul_host_rsp_cap.sv
// Module: response latch and sticky error.
// Latches reply data on got_rsp_i with a one-cycle valid pulse; any fault
// sets the error flag, which only reset clears.
module tlul_host_rsp_cap #(
    parameter int DW = 32
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          got_rsp_i,
    input  logic [DW-1:0] d_data_i,
    input  logic          fault_i,
    output logic          rsp_valid_o,
    output logic [DW-1:0] rsp_data_o,
    output logic          err_o
);
    // Response data latch and valid pulse.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            rsp_valid_o <= 1'b0;
            rsp_data_o  <= '0;
        end else begin
            rsp_valid_o <= got_rsp_i;
            if (got_rsp_i) begin
                rsp_data_o <= d_data_i;
            end
        end
    end

    // Sticky error flag.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            err_o <= 1'b0;
        end else if (fault_i) begin
            err_o <= 1'b1;
        end
    end

endmodule

// File: rtl/tlul_host_seq.sv
// Module: top of the single-access link host sequencer.
// Wires the phase sequencer, two wait-bound counters (ready wait, reply
// wait), the packet holder and the response latch.
// Assumes one access in flight at a time and bounds of at least 1.
module tlul_host_seq
    import tlul_host_pkg::*;
#(
    parameter int AW        = 32,
    parameter int DW        = 32,
    parameter int RDY_BOUND = 8,
    parameter int RSP_BOUND = 16
) (
    input  logic           clk_i,
    input  logic           rst_ni,
    input  logic           req_valid_i,
    input  logic [OPW-1:0] req_opcode_i,
    input  logic [AW-1:0]  req_addr_i,
    input  logic [DW-1:0]  req_data_i,
    input  logic [SZW-1:0] req_size_i,
    output logic           req_taken_o,
    output logic           a_valid_o,
    output logic [OPW-1:0] a_opcode_o,
    output logic [AW-1:0]  a_address_o,
    output logic [DW-1:0]  a_data_o,
    output logic [SZW-1:0] a_size_o,
    input  logic           a_ready_i,
    input  logic           d_valid_i,
    input  logic [DW-1:0]  d_data_i,
    output logic           d_ready_o,
    output logic           rsp_valid_o,
    output logic [DW-1:0]  rsp_data_o,
    output logic           err_o
);
    localparam int NCNT    = 2;  // index 0: ready wait, index 1: reply wait
    localparam int IDX_RDY = 0;
    localparam int IDX_RSP = 1;

    phase_e          phase;
    logic            accept;
    logic            got_rsp;
    logic            fault;
    logic [NCNT-1:0] cnt_load;
    logic [NCNT-1:0] cnt_dec;
    logic [NCNT-1:0] cnt_zero;

    tlul_host_phase_fsm u_fsm (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .req_valid_i (req_valid_i),
        .a_ready_i   (a_ready_i),
        .d_valid_i   (d_valid_i),
        .rdy_zero_i  (cnt_zero[IDX_RDY]),
        .rsp_zero_i  (cnt_zero[IDX_RSP]),
        .phase_o     (phase),
        .accept_o    (accept),
        .rdy_load_o  (cnt_load[IDX_RDY]),
        .rdy_dec_o   (cnt_dec[IDX_RDY]),
        .rsp_load_o  (cnt_load[IDX_RSP]),
        .rsp_dec_o   (cnt_dec[IDX_RSP]),
        .got_rsp_o   (got_rsp),
        .fault_o     (fault)
    );

    // One bound counter per wait phase, each with its own bound.
    for (genvar g = 0; g < NCNT; g++) begin : g_bound
        tlul_host_bound_cnt #(
            .BOUND ((g == IDX_RDY) ? RDY_BOUND : RSP_BOUND)
        ) u_cnt (
            .clk_i  (clk_i),
            .rst_ni (rst_ni),
            .load_i (cnt_load[g]),
            .dec_i  (cnt_dec[g]),
            .zero_o (cnt_zero[g])
        );
    end

    tlul_host_pkt_reg #(
        .AW (AW),
        .DW (DW)
    ) u_pkt (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .capture_i (accept),
        .opcode_i  (req_opcode_i),
        .addr_i    (req_addr_i),
        .data_i    (req_data_i),
        .size_i    (req_size_i),
        .opcode_o  (a_opcode_o),
        .addr_o    (a_address_o),
        .data_o    (a_data_o),
        .size_o    (a_size_o)
    );

    tlul_host_rsp_cap #(
        .DW (DW)
    ) u_rsp (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .got_rsp_i   (got_rsp),
        .d_data_i    (d_data_i),
        .fault_i     (fault),
        .rsp_valid_o (rsp_valid_o),
        .rsp_data_o  (rsp_data_o),
        .err_o       (err_o)
    );

    // Channel handshake outputs decoded from the phase.
    always_comb begin
        a_valid_o = (phase == PH_SEND);
        d_ready_o = (phase == PH_SEND) || (phase == PH_WAIT_RSP);
    end

    assign req_taken_o = accept;

endmodule

// File: rtl/tlul_host_seq_chk.sv
// Module: protocol checker for the link host sequencer, bound to the top.
// Assumes synchronous active-low reset; all properties are disabled during it.
module tlul_host_seq_chk #(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input logic          clk_i,
    input logic          rst_ni,
    input logic          a_valid_o,
    input logic          d_ready_o,
    input logic          a_ready_i,
    input logic          d_valid_i,
    input logic [DW-1:0] d_data_i,
    input logic          req_taken_o,
    input logic [AW-1:0] a_address_o,
    input logic [DW-1:0] a_data_o,
    input logic          rsp_valid_o,
    input logic [DW-1:0] rsp_data_o,
    input logic          err_o
);
    // Send lasts a single cycle.
    assert_single_send_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        a_valid_o |=> !a_valid_o);

    // While sending, the response channel is ready.
    assert_ready_in_send_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        a_valid_o |-> d_ready_o);

    // A taken request with the device ready is sent next cycle.
    assert_direct_send_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        req_taken_o && a_ready_i |=> a_valid_o);

    // Reply accepted: data reported next cycle.
    assert_rsp_capture_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        d_valid_i && d_ready_o && !a_valid_o |=> rsp_valid_o && (rsp_data_o == $past(d_data_i)));

    // Out-of-phase response raises the error.
    assert_stray_err_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        d_valid_i && !d_ready_o |=> err_o);

    // Error is sticky.
    assert_err_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        err_o |=> err_o);

    // Packet stays put across the send cycle.
    assert_pkt_stable_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        a_valid_o |=> $stable(a_address_o) && $stable(a_data_o));

endmodule

bind tlul_host_seq tlul_host_seq_chk #(
    .AW (AW),
    .DW (DW)
) i_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .a_valid_o   (a_valid_o),
    .d_ready_o   (d_ready_o),
    .a_ready_i   (a_ready_i),
    .d_valid_i   (d_valid_i),
    .d_data_i    (d_data_i),
    .req_taken_o (req_taken_o),
    .a_address_o (a_address_o),
    .a_data_o    (a_data_o),
    .rsp_valid_o (rsp_valid_o),
    .rsp_data_o  (rsp_data_o),
    .err_o       (err_o)
);

// File: tb/test_tlul_host_seq.sv
module test_tlul_host_seq;
    localparam int CLK_PERIOD = 10;
    localparam int AW  = 16;
    localparam int DW  = 32;
    localparam int RB  = 3;
    localparam int RSB = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_v = 1'b0;
    logic [2:0]    req_op = '0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_data = '0;
    logic [1:0]    req_size = '0;
    logic          a_rdy = 1'b0;
    logic          d_v = 1'b0;
    logic [DW-1:0] d_dat = '0;

    logic          req_taken, a_valid, d_ready, rsp_valid, err;
    logic [2:0]    a_op;
    logic [AW-1:0] a_addr;
    logic [DW-1:0] a_data, rsp_data;
    logic [1:0]    a_size;

    tlul_host_seq #(.AW(AW), .DW(DW), .RDY_BOUND(RB), .RSP_BOUND(RSB)) i_tlul_host_seq (
        .clk_i(clk), .rst_ni(rst_n),
        .req_valid_i(req_v), .req_opcode_i(req_op), .req_addr_i(req_addr),
        .req_data_i(req_data), .req_size_i(req_size), .req_taken_o(req_taken),
        .a_valid_o(a_valid), .a_opcode_o(a_op), .a_address_o(a_addr),
        .a_data_o(a_data), .a_size_o(a_size), .a_ready_i(a_rdy),
        .d_valid_i(d_v), .d_data_i(d_dat), .d_ready_o(d_ready),
        .rsp_valid_o(rsp_valid), .rsp_data_o(rsp_data), .err_o(err)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_checks = 0;
    int n_errors = 0;

    // Behavioural model: 0 idle, 1 ready wait, 2 send, 3 reply wait.
    int            m_phase, m_cr, m_cs;
    bit            m_err, m_rv;
    logic [2:0]    m_op;
    logic [AW-1:0] m_addr;
    logic [DW-1:0] m_data, m_rd;
    logic [1:0]    m_size;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic bit m_take();
        return req_v && (m_phase == 0 || (m_phase == 3 && d_v));
    endfunction

    task automatic model_reset();
        m_phase = 0; m_cr = 0; m_cs = 0; m_err = 0; m_rv = 0;
        m_op = '0; m_addr = '0; m_data = '0; m_size = '0; m_rd = '0;
    endtask

    task automatic model_capture();
        m_op = req_op; m_addr = req_addr; m_data = req_data; m_size = req_size;
    endtask

    task automatic model_update();
        bit take;
        take = m_take();
        if (d_v && m_phase != 3) m_err = 1;
        m_rv = (m_phase == 3) && d_v;
        if (m_rv) m_rd = d_dat;
        case (m_phase)
            0: if (req_v) begin
                   model_capture();
                   if (a_rdy) m_phase = 2; else begin m_phase = 1; m_cr = RB; end
               end
            1: if (a_rdy) m_phase = 2;
               else if (m_cr == 0) begin m_err = 1; m_phase = 0; end
               else m_cr--;
            2: begin m_phase = 3; m_cs = RSB; end
            default: if (d_v) begin
                   if (take) begin
                       model_capture();
                       if (a_rdy) m_phase = 2; else begin m_phase = 1; m_cr = RB; end
                   end else m_phase = 0;
               end else if (m_cs == 0) begin m_err = 1; m_phase = 0; end
               else m_cs--;
        endcase
    endtask

    task automatic compare_all();
        chk("R2 a_valid", 64'(a_valid), 64'(m_phase == 2));
        chk("R3 d_ready", 64'(d_ready), 64'(m_phase == 2 || m_phase == 3));
        chk("R11 req_taken", 64'(req_taken), 64'(m_take()));
        chk("R8 err", 64'(err), 64'(m_err));
        chk("R6 rsp_valid", 64'(rsp_valid), 64'(m_rv));
        chk("R6 rsp_data", 64'(rsp_data), 64'(m_rd));
        chk("R9 a_opcode", 64'(a_op), 64'(m_op));
        chk("R9 a_address", 64'(a_addr), 64'(m_addr));
        chk("R9 a_data", 64'(a_data), 64'(m_data));
        chk("R9 a_size", 64'(a_size), 64'(m_size));
    endtask

    // One cycle: drive at the falling edge, compare, clock, update the model.
    task automatic step(input bit rv, input logic [2:0] op, input logic [AW-1:0] ad,
                        input logic [DW-1:0] wd, input logic [1:0] sz,
                        input bit ar, input bit dv, input logic [DW-1:0] dd);
        req_v = rv; req_op = op; req_addr = ad; req_data = wd; req_size = sz;
        a_rdy = ar; d_v = dv; d_dat = dd;
        #1;
        compare_all();
        @(posedge clk);
        model_update();
        @(negedge clk);
    endtask

    task automatic quiet(input bit ar);
        step(0, 3'd0, '0, '0, 2'd0, ar, 0, '0);
    endtask

    task automatic do_reset();
        rst_n = 0; req_v = 0; a_rdy = 0; d_v = 0;
        repeat (2) @(posedge clk);
        model_reset();
        @(negedge clk);
        rst_n = 1;
        #1;
        chk("R1 reset a_valid", 64'(a_valid), 64'd0);
        chk("R1 reset d_ready", 64'(d_ready), 64'd0);
        chk("R1 reset err", 64'(err), 64'd0);
        chk("R1 reset rsp_valid", 64'(rsp_valid), 64'd0);
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        n_errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        do_reset();

        // Immediate send, Get opcode (4), then reply after two waits.
        step(1, 3'd4, 16'h1234, 32'h0, 2'd2, 1, 0, '0);
        chk("R4 direct send", 64'(a_valid), 64'd1);
        quiet(0);
        quiet(0);
        quiet(0);
        step(0, 3'd0, '0, '0, 2'd0, 0, 1, 32'hCAFE_F00D);
        chk("R6 pulse", 64'(rsp_valid), 64'd1);
        chk("R6 data", 64'(rsp_data), 64'hCAFE_F00D);
        quiet(0);
        chk("R6 pulse one cycle", 64'(rsp_valid), 64'd0);

        // Delayed send: ready seen after two low cycles in the wait.
        step(1, 3'd0, 16'hBEEF, 32'h1111_2222, 2'd1, 0, 0, '0);
        quiet(0);
        quiet(0);
        chk("R4 still waiting", 64'(a_valid), 64'd0);
        quiet(1);
        chk("R4 delayed send", 64'(a_valid), 64'd1);
        quiet(0);
        // Back-to-back reply with ready high: straight to send.
        step(1, 3'd1, 16'h0042, 32'hAAAA_5555, 2'd0, 1, 1, 32'h0000_0077);
        chk("R10 direct resend", 64'(a_valid), 64'd1);
        chk("R10 new address", 64'(a_addr), 64'h0042);
        quiet(0);
        // Back-to-back reply with ready low: into the ready wait.
        step(1, 3'd4, 16'h0099, 32'h0, 2'd2, 0, 1, 32'h0000_0088);
        chk("R10 wait entered", 64'(a_valid), 64'd0);
        chk("R10 d_ready low", 64'(d_ready), 64'd0);
        // Ready arrives exactly on the last allowed cycle.
        quiet(0); quiet(0); quiet(0);
        chk("R5 no early timeout", 64'(err), 64'd0);
        quiet(1);
        chk("R5 last-cycle ready", 64'(a_valid), 64'd1);
        quiet(0);
        // Reply on the last allowed cycle.
        quiet(0); quiet(0); quiet(0); quiet(0);
        chk("R7 still waiting", 64'(d_ready), 64'd1);
        step(0, 3'd0, '0, '0, 2'd0, 0, 1, 32'h5A5A_5A5A);
        chk("R7 last-cycle reply", 64'(err), 64'd0);

        // Ready-wait timeout.
        do_reset();
        step(1, 3'd0, 16'h0F0F, 32'h1, 2'd3, 0, 0, '0);
        quiet(0); quiet(0); quiet(0);
        chk("R5 before bound", 64'(err), 64'd0);
        quiet(0);
        chk("R5 timeout err", 64'(err), 64'd1);
        quiet(1);
        chk("R5 no send after timeout", 64'(a_valid), 64'd0);

        // Reply-wait timeout.
        do_reset();
        step(1, 3'd4, 16'h7777, 32'h0, 2'd2, 1, 0, '0);
        quiet(0);
        quiet(0); quiet(0); quiet(0); quiet(0);
        chk("R7 before bound", 64'(err), 64'd0);
        quiet(0);
        chk("R7 timeout err", 64'(err), 64'd1);
        chk("R7 d_ready dropped", 64'(d_ready), 64'd0);

        // Stray response in idle, then stickiness.
        do_reset();
        step(0, 3'd0, '0, '0, 2'd0, 0, 1, 32'h1);
        chk("R8 stray err", 64'(err), 64'd1);
        quiet(0); quiet(1);
        chk("R8 sticky", 64'(err), 64'd1);

        // Stray response during send.
        do_reset();
        step(1, 3'd0, 16'h3333, 32'h4444, 2'd2, 1, 0, '0);
        step(0, 3'd0, '0, '0, 2'd0, 0, 1, 32'h2);
        chk("R8 stray in send", 64'(err), 64'd1);
        chk("R2 reply wait after send", 64'(a_valid), 64'd0);
        quiet(0);

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule